// File: doc/BRIEF.md
# Two-Wire Byte Shift Engine

This block is the bit-level engine of a two-wire serial port. It holds one byte in a shift register that puts its most significant bit on SDA and takes in a new bit on every SCL period, and a small edge counter that counts both SCL edges so that software can tell when a byte, or a shorter field such as an acknowledge bit, has gone by. Both bus lines are open-drain. The block either pulls a line low or lets it go, and it reads back the resolved line level through a synchroniser.

As a master, the block never makes its own clock. SCL follows a port-control input that software toggles. Software must watch the synchronised SCL level, because another device may keep the line low after the master lets it go. As a slave, a clock control unit pulls SCL low once a start condition or a counter overflow has been flagged. This stretches the bus until software clears the flag. Addressing, acknowledge policy and data direction are left to software.

Top module: `tw_shift_unit`

## Requirements
- R1: After reset the block releases SCL and SDA, the data register reads 0xFF, the counter reads 0, and both the start flag and the overflow flag are clear.
- R2: The block pulls SDA low exactly when bit 7 (the MSB) of the data register is 0, so a byte goes out bit 7 first.
- R3: On each falling SCL edge the data register shifts left by one. Bit 0 takes the SDA level sampled at the previous rising SCL edge. A rising edge alone leaves the data register unchanged.
- R4: The 4-bit counter goes up by one on every SCL edge, rising and falling, and wraps from 15 to 0.
- R5: The overflow flag sets on the edge that wraps the counter from 15 to 0. A preset value P makes it set after 16-P edges. A preset of 14 sets it after two edges.
- R6: The start flag sets when SDA falls while SCL is high. An SDA fall while SCL is low leaves the flag clear.
- R7: In slave mode (slave_mode=1), once the start flag or the overflow flag is set and SCL is low, the block pulls SCL low. It keeps holding until both flags are clear. Clearing a flag that is not set does not release the hold.
- R8: In master mode (slave_mode=0), scl_drive_low is the inverse of port_scl, delayed by one clock. The flags never stretch SCL in this mode.
- R9: scl_state reports the synchronised SCL line level. A rise that another device holds off is neither reported nor counted until the line actually goes high.
- R10: A data write or a counter write sets the data register or the counter to the written value on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | 1 = slave role (clock control unit active), 0 = master role |
| port_scl | input | 1 | Master SCL control bit: 1 releases SCL, 0 pulls it low |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| data_wr | input | 1 | Load the data register |
| data_wdata | input | 8 | Value for the data register |
| cnt_wr | input | 1 | Preset the edge counter |
| cnt_wdata | input | 4 | Preset value for the counter |
| start_clr | input | 1 | Clear the start flag |
| ovf_clr | input | 1 | Clear the overflow flag |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |
| scl_state | output | 1 | Synchronised SCL level |
| data_q | output | 8 | Data register contents |
| cnt_q | output | 4 | Edge counter value |
| start_flag | output | 1 | Start condition seen |
| ovf_flag | output | 1 | Counter overflow seen |

## Verification
The shift and counter properties assume that software never loads the data register or presets the counter in the cycle where a synchronised SCL edge is acted on. They also assume that each line level lasts longer than the synchroniser delay, so that every physical edge appears as exactly one internal edge. The directed stimulus keeps every bus level stable for eight clocks, which is several times the two-stage sync latency. It issues host writes and flag clears only while SCL is being held steady, either by the bench or by the block itself. Bus changes that carry data happen only while SCL is low, and a start condition is made on purpose only with SCL high.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } line_ev_t;

  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } role_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync
  import tw_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     din,
  output line_ev_t ev
);
  logic [STAGES-1:0] sh;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= sh[STAGES-1];
  end

  assign ev.level = sh[STAGES-1];
  assign ev.rise  = sh[STAGES-1] & ~prev;
  assign ev.fall  = ~sh[STAGES-1] & prev;
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter
  import tw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  line_ev_t          scl,
  input  logic              sda_level,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] data_q,
  output logic              sda_low
);
  localparam int MSB = DATA_W - 1;

  logic sampled_bit;

  always_ff @(posedge clk) begin
    if (rst)           sampled_bit <= 1'b1;
    else if (scl.rise) sampled_bit <= sda_level;
  end

  always_ff @(posedge clk) begin
    if (rst)           data_q <= '1;
    else if (load)     data_q <= load_data;
    else if (scl.fall) data_q <= {data_q[MSB-1:0], sampled_bit};
  end

  assign sda_low = ~data_q[MSB];
endmodule

// File: rtl/tw_edge_counter.sv
module tw_edge_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             preset,
  input  logic [CNT_W-1:0] preset_val,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_flag
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic wrap;
  assign wrap = step & ~preset & (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (preset) cnt_q <= preset_val;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_flag <= 1'b0;
    else if (wrap)    ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/tw_clk_ctrl.sv
module tw_clk_ctrl
  import tw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  role_e    role,
  input  logic     port_scl,
  input  line_ev_t scl,
  input  line_ev_t sda,
  input  logic     start_clr,
  input  logic     ovf_flag,
  output logic     start_flag,
  output logic     scl_low
);
  logic start_seen;
  logic hold_q;
  logic hold_next;

  assign start_seen = scl.level & sda.fall;

  always_ff @(posedge clk) begin
    if (rst)             start_flag <= 1'b0;
    else if (start_seen) start_flag <= 1'b1;
    else if (start_clr)  start_flag <= 1'b0;
  end

  assign hold_next = (role == ROLE_SLAVE) & (start_flag | ovf_flag) &
                     (hold_q | ~scl.level);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      scl_low <= 1'b0;
    end else begin
      hold_q  <= hold_next;
      scl_low <= (role == ROLE_MASTER) ? ~port_scl : hold_next;
    end
  end
endmodule

// File: rtl/tw_shift_unit.sv
module tw_shift_unit
  import tw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slave_mode,
  input  logic              port_scl,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              start_clr,
  input  logic              ovf_clr,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              scl_state,
  output logic [DATA_W-1:0] data_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              start_flag,
  output logic              ovf_flag
);
  line_ev_t scl_ev;
  line_ev_t sda_ev;
  role_e    role;
  logic     edge_step;

  assign role      = slave_mode ? ROLE_SLAVE : ROLE_MASTER;
  assign edge_step = scl_ev.rise | scl_ev.fall;
  assign scl_state = scl_ev.level;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_in), .ev(scl_ev)
  );

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .din(sda_in), .ev(sda_ev)
  );

  tw_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .scl(scl_ev), .sda_level(sda_ev.level),
    .load(data_wr), .load_data(data_wdata), .data_q(data_q),
    .sda_low(sda_drive_low)
  );

  tw_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(edge_step), .preset(cnt_wr),
    .preset_val(cnt_wdata), .ovf_clr(ovf_clr), .cnt_q(cnt_q),
    .ovf_flag(ovf_flag)
  );

  tw_clk_ctrl u_ctrl (
    .clk(clk), .rst(rst), .role(role), .port_scl(port_scl),
    .scl(scl_ev), .sda(sda_ev), .start_clr(start_clr),
    .ovf_flag(ovf_flag), .start_flag(start_flag), .scl_low(scl_drive_low)
  );
endmodule

module tw_shift_unit_chk
  import tw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              slave_mode,
  input logic              port_scl,
  input logic              data_wr,
  input logic              cnt_wr,
  input logic              scl_drive_low,
  input logic [DATA_W-1:0] data_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              start_flag,
  input logic              ovf_flag,
  input line_ev_t          scl_ev,
  input line_ev_t          sda_ev
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_shift_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (scl_ev.fall && !data_wr) |=> data_q[DATA_W-1:1] == $past(data_q[DATA_W-2:0]));

  p_rise_keeps_data_r3: assert property (@(posedge clk) disable iff (rst)
    (scl_ev.rise && !data_wr) |=> $stable(data_q));

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    ((scl_ev.rise || scl_ev.fall) && !cnt_wr) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_cnt_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!scl_ev.rise && !scl_ev.fall && !cnt_wr) |=> $stable(cnt_q));

  p_ovf_on_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    ((scl_ev.rise || scl_ev.fall) && !cnt_wr && cnt_q == TOP) |=> ovf_flag);

  p_start_seen_r6: assert property (@(posedge clk) disable iff (rst)
    (scl_ev.level && sda_ev.fall) |=> start_flag);

  p_no_hold_wo_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (slave_mode && !start_flag && !ovf_flag) |=> !scl_drive_low);

  p_master_follows_port_r8: assert property (@(posedge clk) disable iff (rst)
    (!slave_mode) |=> scl_drive_low == !$past(port_scl));
endmodule

bind tw_shift_unit tw_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .slave_mode(slave_mode), .port_scl(port_scl),
  .data_wr(data_wr), .cnt_wr(cnt_wr), .scl_drive_low(scl_drive_low),
  .data_q(data_q), .cnt_q(cnt_q), .start_flag(start_flag),
  .ovf_flag(ovf_flag), .scl_ev(scl_ev), .sda_ev(sda_ev)
);

// File: tb/sim_tw_shift_unit.sv
`timescale 1ns/1ps
module sim_tw_shift_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slave_mode = 1'b0;
  logic       port_scl = 1'b1;
  logic       data_wr = 1'b0;
  logic [7:0] data_wdata = '0;
  logic       cnt_wr = 1'b0;
  logic [3:0] cnt_wdata = '0;
  logic       start_clr = 1'b0;
  logic       ovf_clr = 1'b0;
  logic       tb_scl_pull = 1'b0;
  logic       tb_sda_pull = 1'b0;
  logic       scl_drive_low, sda_drive_low, scl_state, start_flag, ovf_flag;
  logic [7:0] data_q;
  logic [3:0] cnt_q;
  logic       scl_line, sda_line;
  int         checks = 0;
  int         errors = 0;
  int         cycles = 0;

  always #4 clk = ~clk;

  assign scl_line = ~(scl_drive_low | tb_scl_pull);
  assign sda_line = ~(sda_drive_low | tb_sda_pull);

  tw_shift_unit u0 (
    .clk(clk), .rst(rst), .slave_mode(slave_mode), .port_scl(port_scl),
    .scl_in(scl_line), .sda_in(sda_line), .data_wr(data_wr),
    .data_wdata(data_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .start_clr(start_clr), .ovf_clr(ovf_clr), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .scl_state(scl_state), .data_q(data_q),
    .cnt_q(cnt_q), .start_flag(start_flag), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic host_data(input logic [7:0] v);
    @(negedge clk); data_wr = 1'b1; data_wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic host_cnt(input logic [3:0] v);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic clear_start();
    @(negedge clk); start_clr = 1'b1;
    @(negedge clk); start_clr = 1'b0;
  endtask

  task automatic clear_ovf();
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scl drive", {7'd0, scl_drive_low}, 8'd0);
    chk("R1 sda drive", {7'd0, sda_drive_low}, 8'd0);
    chk("R1 data", data_q, 8'hFF);
    chk("R1 count", {4'd0, cnt_q}, 8'd0);
    chk("R1 flags", {6'd0, start_flag, ovf_flag}, 8'd0);
  endtask

  task automatic t_host_write();
    host_data(8'h5A);
    chk("R10 data write", data_q, 8'h5A);
    chk("R2 msb zero drives sda", {7'd0, sda_drive_low}, 8'd1);
    host_cnt(4'd9);
    chk("R10 count write", {4'd0, cnt_q}, 8'd9);
    host_data(8'hFF);
    host_cnt(4'd0);
    settle();
    clear_start();
    chk("R2 msb one releases sda", {7'd0, sda_drive_low}, 8'd0);
  endtask

  task automatic t_master_tx();
    logic [7:0] byte_out = 8'hA5;
    slave_mode = 1'b0;
    host_data(8'h00);
    settle();
    chk("R6 start with scl high", {7'd0, start_flag}, 8'd1);
    chk("R8 master no hold at start", {7'd0, scl_line}, 8'd1);
    port_scl = 1'b0;
    settle();
    chk("R8 port low drives scl", {7'd0, scl_drive_low}, 8'd1);
    host_data(byte_out);
    host_cnt(4'd0);
    clear_start();
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) begin
        tb_scl_pull = 1'b1;
        port_scl = 1'b1;
        settle();
        chk("R9 stretched scl reads low", {7'd0, scl_state}, 8'd0);
        chk("R9 held-off rise not counted", {4'd0, cnt_q}, 8'd6);
        tb_scl_pull = 1'b0;
      end else begin
        port_scl = 1'b1;
      end
      settle();
      chk("R2 sda carries bit msb first", {7'd0, sda_line}, {7'd0, byte_out[i]});
      if (i == 7) chk("R4 rising edge counts", {4'd0, cnt_q}, 8'd1);
      port_scl = 1'b0;
      settle();
      if (i == 7) chk("R4 falling edge counts", {4'd0, cnt_q}, 8'd2);
    end
    chk("R3 shifted byte", data_q, byte_out);
    chk("R5 overflow after 16 edges", {7'd0, ovf_flag}, 8'd1);
    chk("R4 counter wrapped", {4'd0, cnt_q}, 8'd0);
  endtask

  task automatic t_master_nohold();
    port_scl = 1'b1;
    settle();
    chk("R8 master ignores overflow hold", {7'd0, scl_drive_low}, 8'd0);
    chk("R9 scl state high", {7'd0, scl_state}, 8'd1);
    host_data(8'hFF);
    clear_ovf();
    settle();
  endtask

  task automatic t_slave_rx();
    logic [7:0] byte_in = 8'h3C;
    slave_mode = 1'b1;
    settle();
    tb_sda_pull = 1'b1;
    settle();
    chk("R6 slave sees start", {7'd0, start_flag}, 8'd1);
    chk("R7 no hold while scl high", {7'd0, scl_drive_low}, 8'd0);
    tb_scl_pull = 1'b1;
    settle();
    chk("R7 hold after scl low", {7'd0, scl_drive_low}, 8'd1);
    tb_scl_pull = 1'b0;
    settle();
    chk("R7 line stretched low", {7'd0, scl_line}, 8'd0);
    clear_ovf();
    settle();
    chk("R7 clearing other flag keeps hold", {7'd0, scl_drive_low}, 8'd1);
    tb_scl_pull = 1'b1;
    host_cnt(4'd0);
    clear_start();
    settle();
    chk("R7 hold released", {7'd0, scl_drive_low}, 8'd0);
    for (int i = 7; i >= 0; i--) begin
      tb_sda_pull = ~byte_in[i];
      settle();
      tb_scl_pull = 1'b0;
      settle();
      if (i == 7) begin
        chk("R4 count after rise", {4'd0, cnt_q}, 8'd1);
        chk("R3 rise keeps data", data_q, 8'hFF);
      end
      tb_scl_pull = 1'b1;
      settle();
    end
    chk("R3 received byte", data_q, byte_in);
    chk("R5 overflow set", {7'd0, ovf_flag}, 8'd1);
    chk("R7 hold after overflow", {7'd0, scl_drive_low}, 8'd1);
    host_data(8'hFF);
    host_cnt(4'd14);
    clear_ovf();
    tb_sda_pull = 1'b0;
    settle();
    chk("R7 release after clear", {7'd0, scl_drive_low}, 8'd0);
    tb_scl_pull = 1'b0;
    settle();
    chk("R5 preset one edge in", {4'd0, cnt_q}, 8'd15);
    chk("R5 no overflow yet", {7'd0, ovf_flag}, 8'd0);
    tb_scl_pull = 1'b1;
    settle();
    chk("R5 overflow after two edges", {7'd0, ovf_flag}, 8'd1);
    chk("R7 hold after short field", {7'd0, scl_drive_low}, 8'd1);
    clear_ovf();
    tb_scl_pull = 1'b0;
    settle();
    chk("R7 scl free again", {7'd0, scl_line}, 8'd1);
  endtask

  task automatic t_start_low();
    tb_scl_pull = 1'b1;
    settle();
    tb_sda_pull = 1'b1;
    settle();
    chk("R6 no start with scl low", {7'd0, start_flag}, 8'd0);
    tb_sda_pull = 1'b0;
    settle();
    tb_scl_pull = 1'b0;
    settle();
    chk("R6 flag still clear", {7'd0, start_flag}, 8'd0);
    chk("R7 no hold without flag", {7'd0, scl_drive_low}, 8'd0);
  endtask

  initial begin
    t_reset();
    t_host_write();
    t_master_tx();
    t_master_nohold();
    t_slave_rx();
    t_start_low();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule